// File: doc/BRIEF.md
# Per-Phase Sticky Fault Status Register (Communication, Logic, Memory)

This block holds one latched fault byte for each power phase of a multi-phase controller that is managed over a byte-oriented management bus. Fault detectors elsewhere in the chip send single-cycle event pulses, one for each bit position and phase. Each pulse sets its bit, and the bit then stays set until firmware or a host clears it. Six bit positions are supported: invalid command (bit 7), invalid data (bit 6), packet check failure (bit 5), memory fault (bit 4), logic core fault (bit 3) and communication fault (bit 1). Positions 2 and 0 are reserved and always read zero.

The bus engine presents a command code, a phase selector and read or write strobes. Command code 0x7E addresses this register. A byte read returns the selected phase's byte. A byte write clears every bit where the written data holds a one, and only in the selected phase. A global clear strobe wipes every phase. For each phase the block drives a summary bit that feeds the higher-level status byte. It also drives one alert request: the OR, across all phases, of set bits that the shared mask does not suppress. On phases configured as followers, a back-channel link error is recorded as a communication fault.

Top module: `cml_fault_bank`

## Requirements
- R1: After a synchronous reset every phase's byte is 0x00, `rd_data` is 0x00, `summary` is all zeros and `alert` is 0.
- R2: An event pulse on a supported position (bits 7, 6, 5, 4, 3, 1 of the phase's byte in `ev_bits`, phase p at bits p*8+7..p*8) sets that bit on the next clock edge. The bit stays 1 until it is cleared.
- R3: Bits 2 and 0 (mask 0x05) always read 0. Events and writes at those positions have no effect.
- R4: A write (`wr_en`) with `cmd_code` 0x7E clears, in the phase given by `phase_sel`, each bit whose `wr_data` bit is 1, and leaves the bits written with 0 unchanged.
- R5: A write or read with any `cmd_code` other than 0x7E changes no state. Such a read loads 0x00 into `rd_data`.
- R6: A read (`rd_en`) with `cmd_code` 0x7E loads the selected phase's byte, as it stood before the edge, into `rd_data` one cycle later. `rd_data` holds its value when no read occurs. A write changes only the selected phase.
- R7: `clear_faults` clears all bits of all phases on the next edge.
- R8: When an event and a clear (a one-write or `clear_faults`) reach the same bit in the same cycle, the bit ends up set.
- R9: `summary[p]` is 1 exactly when phase p has at least one supported bit set.
- R10: `alert` is 1 exactly when some phase has a set bit whose `alert_mask` bit is 0. A mask bit of 1 suppresses that position in every phase, and a mask change takes effect in the same cycle.
- R11: `bc_err[p]` sets bit 1 of phase p when p is a follower (`FOLLOWER_MASK[p]` = 1, default: all phases except phase 0). On the leader phase it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_code | input | 8 | Command code of the current bus access |
| phase_sel | input | PW | Currently selected phase |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Write data; ones clear bits |
| rd_en | input | 1 | Byte read strobe |
| rd_data | output | 8 | Registered read data |
| clear_faults | input | 1 | Global clear of all phases |
| ev_bits | input | NPH*8 | Fault event pulses, one byte per phase |
| bc_err | input | NPH | Back-channel link error pulse per phase |
| alert_mask | input | 8 | Alert mask; 1 suppresses a position |
| summary | output | NPH | Per-phase OR of latched bits |
| alert | output | 1 | Masked alert request across phases |

## Verification
Directed sequences isolate single effects. One pattern sets a bit and then idles, which shows the bit is sticky. Others clear one chosen bit next to its neighbours, and drive only the reserved positions, which shows they ignore every stimulus. A further set reads a wrong command code next to the right one, which tells command decoding apart from phase selection. Event and clear are also applied in the same cycle, to show that the set wins. Constrained random traffic then mixes sparse events, back-channel errors, writes, reads, global clears and mask changes across all phases. This uncovers cross-phase leakage and priority mistakes, because every cycle's summary, alert and read data are compared with a reference model.

// File: rtl/cml_pkg.sv
package cml_pkg;
  localparam logic [7:0] CML_CODE     = 8'h7E;
  localparam logic [7:0] CML_SUP_MASK = 8'hFA;
  localparam logic [7:0] CML_COMM_BIT = 8'h02;
  typedef logic [7:0] cml_byte_t;
endpackage

// File: rtl/cml_phase_reg.sv
module cml_phase_reg
  import cml_pkg::*;
#(
  parameter bit FOLLOWER = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      clr_all,
  input  logic      wr_hit,
  input  cml_byte_t wr_data,
  input  cml_byte_t ev,
  input  logic      bc_err,
  output cml_byte_t q
);
  cml_byte_t keep_v, set_v, nxt;
  logic      bc_set;

  assign bc_set = FOLLOWER ? bc_err : 1'b0;

  always_comb begin
    if (clr_all)      keep_v = '0;
    else if (wr_hit)  keep_v = q & ~wr_data;
    else              keep_v = q;
    set_v = ev | (bc_set ? CML_COMM_BIT : 8'h00);
    nxt   = (keep_v | set_v) & CML_SUP_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/cml_read_port.sv
module cml_read_port
  import cml_pkg::*;
#(
  parameter int NPH = 4,
  parameter int PW  = (NPH > 1) ? $clog2(NPH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic             cmd_hit,
  input  logic [PW-1:0]    phase_sel,
  input  logic [NPH*8-1:0] state_flat,
  output cml_byte_t        rd_data
);
  cml_byte_t sel_byte;

  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < NPH; i++) begin
      if (phase_sel == PW'(i)) sel_byte = state_flat[i*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= cmd_hit ? sel_byte : 8'h00;
  end
endmodule

// File: rtl/cml_alert_or.sv
module cml_alert_or
  import cml_pkg::*;
#(
  parameter int NPH = 4
) (
  input  logic [NPH*8-1:0] state_flat,
  input  cml_byte_t        alert_mask,
  output logic [NPH-1:0]   summary,
  output logic             alert
);
  cml_byte_t acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NPH; i++) begin
      summary[i] = |(state_flat[i*8 +: 8] & CML_SUP_MASK);
      acc        = acc | (state_flat[i*8 +: 8] & ~alert_mask);
    end
    alert = |acc;
  end
endmodule

// File: rtl/cml_fault_bank.sv
module cml_fault_bank
  import cml_pkg::*;
#(
  parameter int             NPH           = 4,
  parameter int             PW            = (NPH > 1) ? $clog2(NPH) : 1,
  parameter logic [NPH-1:0] FOLLOWER_MASK = {{(NPH-1){1'b1}}, 1'b0}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       cmd_code,
  input  logic [PW-1:0]    phase_sel,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  input  logic             clear_faults,
  input  logic [NPH*8-1:0] ev_bits,
  input  logic [NPH-1:0]   bc_err,
  input  logic [7:0]       alert_mask,
  output logic [NPH-1:0]   summary,
  output logic             alert
);
  logic             cmd_hit;
  logic [NPH*8-1:0] state_flat;

  assign cmd_hit = (cmd_code == CML_CODE);

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    logic wr_hit;
    assign wr_hit = wr_en && cmd_hit && (phase_sel == PW'(p));
    cml_phase_reg #(.FOLLOWER(FOLLOWER_MASK[p])) u_reg (
      .clk     (clk),
      .rst     (rst),
      .clr_all (clear_faults),
      .wr_hit  (wr_hit),
      .wr_data (wr_data),
      .ev      (ev_bits[p*8 +: 8]),
      .bc_err  (bc_err[p]),
      .q       (state_flat[p*8 +: 8])
    );
  end

  cml_read_port #(.NPH(NPH), .PW(PW)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .cmd_hit    (cmd_hit),
    .phase_sel  (phase_sel),
    .state_flat (state_flat),
    .rd_data    (rd_data)
  );

  cml_alert_or #(.NPH(NPH)) u_alert (
    .state_flat (state_flat),
    .alert_mask (alert_mask),
    .summary    (summary),
    .alert      (alert)
  );
endmodule

// File: rtl/cml_fault_bank_chk.sv
module cml_fault_bank_chk
  import cml_pkg::*;
#(
  parameter int NPH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             clear_faults,
  input logic [NPH*8-1:0] ev_bits,
  input logic [NPH-1:0]   bc_err,
  input logic [7:0]       rd_data,
  input logic             alert,
  input logic [NPH*8-1:0] state_flat
);
  localparam logic [NPH*8-1:0] SUP_ALL = {NPH{CML_SUP_MASK}};
  logic [NPH*8-1:0] ev_sup;
  assign ev_sup = ev_bits & SUP_ALL;

  // R2 / R8: a supported event is always latched on the next edge
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (ev_sup != '0) |=> ((state_flat & $past(ev_sup)) == $past(ev_sup)));

  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (!clear_faults && !wr_en) |=> ((state_flat & $past(state_flat)) == $past(state_flat)));

  p_clear_all_r7: assert property (@(posedge clk) disable iff (rst)
    (clear_faults && ev_bits == '0 && bc_err == '0) |=> (state_flat == '0));

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (rst)
    ((state_flat & ~SUP_ALL) == '0) && !rd_data[2] && !rd_data[0]);

  p_alert_needs_fault_r10: assert property (@(posedge clk) disable iff (rst)
    alert |-> (state_flat != '0));
endmodule

bind cml_fault_bank cml_fault_bank_chk #(.NPH(NPH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .clear_faults (clear_faults),
  .ev_bits      (ev_bits),
  .bc_err       (bc_err),
  .rd_data      (rd_data),
  .alert        (alert),
  .state_flat   (state_flat)
);

// File: tb/tb_cml_fault_bank.sv
module tb_cml_fault_bank;
  localparam int NPH = 4;
  localparam int PW  = 2;
  localparam logic [NPH-1:0] FOLL = 4'b1110;
  localparam time CLK_PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             rst;
  logic [7:0]       cmd_code;
  logic [PW-1:0]    phase_sel;
  logic             wr_en;
  logic [7:0]       wr_data;
  logic             rd_en;
  logic [7:0]       rd_data;
  logic             clear_faults;
  logic [NPH*8-1:0] ev_bits;
  logic [NPH-1:0]   bc_err;
  logic [7:0]       alert_mask;
  logic [NPH-1:0]   summary;
  logic             alert;

  logic [7:0] exp_st [NPH];
  logic [7:0] rd_exp;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cml_fault_bank dut (
    .clk(clk), .rst(rst), .cmd_code(cmd_code), .phase_sel(phase_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .clear_faults(clear_faults), .ev_bits(ev_bits), .bc_err(bc_err),
    .alert_mask(alert_mask), .summary(summary), .alert(alert)
  );

  function automatic logic [NPH-1:0] exp_summary();
    logic [NPH-1:0] s;
    for (int p = 0; p < NPH; p++) s[p] = |(exp_st[p] & 8'hFA);
    return s;
  endfunction

  function automatic logic exp_alert();
    logic a = 1'b0;
    for (int p = 0; p < NPH; p++) a |= |(exp_st[p] & ~alert_mask);
    return a;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic drive(logic [NPH*8-1:0] ev, logic [NPH-1:0] bc, logic wr, logic [7:0] wd,
                       logic rd, logic [7:0] cmd, logic [PW-1:0] ph, logic clr);
    ev_bits = ev; bc_err = bc; wr_en = wr; wr_data = wd;
    rd_en = rd; cmd_code = cmd; phase_sel = ph; clear_faults = clr;
  endtask

  task automatic idle();
    drive('0, '0, 1'b0, 8'h00, 1'b0, 8'h00, '0, 1'b0);
  endtask

  // one clock with the current inputs, reference model update, output checks
  task automatic step(string tag);
    logic [7:0] nx [NPH];
    for (int p = 0; p < NPH; p++) begin
      logic [7:0] s = exp_st[p];
      if (clear_faults) s = 8'h00;
      else if (wr_en && cmd_code == 8'h7E && phase_sel == PW'(p)) s &= ~wr_data;
      s |= ev_bits[p*8 +: 8];
      if (bc_err[p] && FOLL[p]) s |= 8'h02;
      nx[p] = s & 8'hFA;
    end
    if (rd_en) rd_exp = (cmd_code == 8'h7E) ? exp_st[phase_sel] : 8'h00;
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NPH; p++) exp_st[p] = nx[p];
    check(tag, "summary", 32'(summary), 32'(exp_summary()));
    check(tag, "alert", 32'(alert), 32'(exp_alert()));
    check(tag, "rd_data", 32'(rd_data), 32'(rd_exp));
  endtask

  task automatic rd(string tag, logic [PW-1:0] ph);
    drive('0, '0, 1'b0, 8'h00, 1'b1, 8'h7E, ph, 1'b0);
    step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20231));
    rst = 1'b1;
    alert_mask = 8'h00;
    idle();
    for (int p = 0; p < NPH; p++) exp_st[p] = 8'h00;
    rd_exp = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", "summary", 32'(summary), 32'h0);
    check("R1", "alert", 32'(alert), 32'h0);
    check("R1", "rd_data", 32'(rd_data), 32'h0);

    // R2: set and hold
    drive(32'h0000_8000, '0, 1'b0, 8'h00, 1'b0, 8'h7E, 2'd0, 1'b0); step("R2");
    idle(); repeat (3) step("R2");
    rd("R2", 2'd1);
    check("R2", "read phase1", 32'(rd_data), 32'h80);

    // R3: reserved positions ignore events and writes
    drive(32'h0005_0000, '0, 1'b1, 8'h05, 1'b0, 8'h7E, 2'd2, 1'b0); step("R3");
    rd("R3", 2'd2);
    check("R3", "read phase2", 32'(rd_data), 32'h00);

    // R4: one-write clears only selected bits
    drive(32'h0000_00FF, '0, 1'b0, 8'h00, 1'b0, 8'h7E, 2'd0, 1'b0); step("R4");
    drive('0, '0, 1'b1, 8'h30, 1'b0, 8'h7E, 2'd0, 1'b0); step("R4");
    rd("R4", 2'd0);
    check("R4", "read phase0", 32'(rd_data), 32'hCA);

    // R5: wrong command code
    drive('0, '0, 1'b1, 8'hFF, 1'b0, 8'h7D, 2'd0, 1'b0); step("R5");
    drive('0, '0, 1'b0, 8'h00, 1'b1, 8'h7D, 2'd0, 1'b0); step("R5");
    check("R5", "wrong-code read", 32'(rd_data), 32'h00);
    rd("R5", 2'd0);
    check("R5", "state kept", 32'(rd_data), 32'hCA);

    // R6: write to phase1 leaves phase0
    drive('0, '0, 1'b1, 8'hFF, 1'b0, 8'h7E, 2'd1, 1'b0); step("R6");
    rd("R6", 2'd0);
    check("R6", "phase0 untouched", 32'(rd_data), 32'hCA);

    // R8: set wins over one-write and over clear_faults
    drive(32'h0000_0010, '0, 1'b1, 8'h10, 1'b0, 8'h7E, 2'd0, 1'b0); step("R8");
    drive(32'h0000_0040, '0, 1'b0, 8'h00, 1'b0, 8'h7E, 2'd0, 1'b1); step("R8");
    rd("R8", 2'd0);
    check("R8", "only new bit", 32'(rd_data), 32'h40);

    // R7: global clear
    drive(32'h0800_0000, '0, 1'b0, 8'h00, 1'b0, 8'h7E, 2'd0, 1'b0); step("R7");
    drive('0, '0, 1'b0, 8'h00, 1'b0, 8'h7E, 2'd0, 1'b1); step("R7");
    check("R7", "summary zero", 32'(summary), 32'h0);

    // R10 / R9: mask suppresses alert, summary still set
    alert_mask = 8'h02;
    drive(32'h0200_0000, '0, 1'b0, 8'h00, 1'b0, 8'h7E, 2'd0, 1'b0); step("R10");
    check("R10", "masked alert", 32'(alert), 32'h0);
    check("R9", "summary phase3", 32'(summary), 32'h8);
    alert_mask = 8'h00;
    idle(); step("R10");
    check("R10", "unmasked alert", 32'(alert), 32'h1);

    // R11: back-channel error on leader and follower
    drive('0, 4'b0001, 1'b0, 8'h00, 1'b0, 8'h7E, 2'd0, 1'b1); step("R11");
    rd("R11", 2'd0);
    check("R11", "leader ignores", 32'(rd_data), 32'h00);
    drive('0, 4'b0100, 1'b0, 8'h00, 1'b0, 8'h7E, 2'd0, 1'b0); step("R11");
    rd("R11", 2'd2);
    check("R11", "follower comm bit", 32'(rd_data), 32'h02);

    // random mix, checked every cycle (R6, R9, R10 and the rest via model)
    for (int n = 0; n < 3000; n++) begin
      logic [NPH*8-1:0] ev = '0;
      logic [NPH-1:0]   bc;
      if (n % 64 == 0) alert_mask = 8'($urandom);
      for (int p = 0; p < NPH; p++)
        if ($urandom % 10 == 0) ev[p*8 +: 8] = 8'($urandom);
      bc = ($urandom % 12 == 0) ? NPH'($urandom) : '0;
      drive(ev, bc, ($urandom % 4 == 0), 8'($urandom), ($urandom % 2 == 0),
            ($urandom % 8 == 0) ? 8'($urandom) : 8'h7E, PW'($urandom),
            ($urandom % 40 == 0));
      step("R6");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule